// File: doc/BRIEF.md
# Interrupt request input controller

This block conditions two active-low external interrupt request pins for a small processor core. The first pin carries a maskable request that can trigger either on a low level or on a falling edge. The choice and an enable bit sit in a two-bit control register. The second pin carries a level-sensitive nonmaskable request. A dedicated mask bit holds it off from reset. Software may clear that bit once, and only reset sets it again.

Both pins pass through a synchronizer before any use. In edge mode a falling edge sets a sticky pending flag, which the core clears with an acknowledge pulse. The block combines the core's maskable-interrupt mask bit with its own state and drives a request code in which the nonmaskable source wins. The block also presents the reset vector address to fetch, which depends on which reset causes are pending.

Top module: `irq_input_ctrl`

## Requirements
- R1: `pin_lvl_o` shows the synchronized pin levels (bit 0 maskable pin, bit 1 nonmaskable pin). A change on a pin is visible on `pin_lvl_o` after the second rising clock edge, whatever the enable, mode and mask state.
- R2: After reset, `cfg_o` reads 2'b01 (bit 0 enable set, bit 1 edge select clear, meaning level mode), `xmask_o` reads 1, `req_id_o` reads 2'b00 and `pin_lvl_o` reads 2'b11.
- R3: In level mode with the block enabled and `imask_i` low, a low maskable pin gives `req_id_o` = 2'b01 two clocks after the pin falls. The request drops two clocks after the pin rises.
- R4: In edge mode a falling edge on the maskable pin sets a pending flag, so `req_id_o` = 2'b01 three clocks after the pin falls. Raising the pin again does not clear the request. An `ack_i` pulse clears it at the next clock edge.
- R5: If `ack_i` is sampled in the same clock edge as a newly detected falling edge, the pending flag stays set.
- R6: A control write that selects level mode clears the edge pending flag. Switching back to edge mode with the pin high gives no request.
- R7: With enable (`cfg_o[0]`) clear, the maskable source never gives `req_id_o` = 2'b01. Falling edges seen while the block is disabled are not latched.
- R8: `imask_i` high blocks the maskable request. Lowering `imask_i` while a level request is active raises `req_id_o` = 2'b01 in the same cycle, with no clock edge needed.
- R9: `xmask_o` is 1 from reset. A write (`xmask_we_i`) with data 0 clears it at the next edge. A write with data 1 has no effect. While `xmask_o` is 1 the nonmaskable pin gives no request.
- R10: With `xmask_o` clear, a low nonmaskable pin gives `req_id_o` = 2'b10. This code takes priority over a maskable request. `req_o` is high whenever `req_id_o` is nonzero.
- R11: `rst_vec_o` is 16'hFFFC when `clkmon_pend_i` is set. Otherwise it is 16'hFFFA when `cop_pend_i` is set, and otherwise 16'hFFFE.
- R12: `cfg_wdata_i` is written into the control register on a clock edge with `cfg_we_i` high, and `cfg_o` shows the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 1 | Maskable request pin, active low |
| nmi_ni | input | 1 | Nonmaskable request pin, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 2 | Control write data: bit 0 enable, bit 1 edge select |
| cfg_o | output | 2 | Control register contents |
| imask_i | input | 1 | Core mask bit for the maskable request |
| xmask_we_i | input | 1 | Nonmaskable mask write strobe |
| xmask_wdata_i | input | 1 | Nonmaskable mask write data (only 0 acts) |
| xmask_o | output | 1 | Nonmaskable mask bit |
| ack_i | input | 1 | Acknowledge pulse, clears the edge pending flag |
| pin_lvl_o | output | 2 | Synchronized pin levels |
| req_o | output | 1 | Any request active |
| req_id_o | output | 2 | 00 none, 01 maskable, 10 nonmaskable |
| cop_pend_i | input | 1 | Watchdog timeout reset pending |
| clkmon_pend_i | input | 1 | Clock monitor failure reset pending |
| rst_vec_o | output | 16 | Reset vector address (high byte) |

## Verification
Two functions can fall in the same clock edge: the core acknowledging a latched edge and the synchronizer reporting a new falling edge. The bench makes them collide by lowering the pin exactly two edges before the edge at which it asserts `ack_i`. It judges the result by checking that the maskable request code is still present after the edge and stays present one cycle later. Sweeps over enable, core mask, both pins and the nonmaskable mask state compare the request code with a value computed from the priority rule.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_MASK = 2'b01,
    REQ_NMI  = 2'b10
  } req_id_e;

  typedef struct packed {
    logic edge_sel;
    logic en;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{edge_sel: 1'b0, en: 1'b1};
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '1;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_n_i,
  input  logic en_i,
  input  logic edge_sel_i,
  input  logic ack_i,
  output logic active_o
);
  logic prev_n;
  logic pend;
  logic fall;

  assign fall = prev_n & ~lvl_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_n <= 1'b1;
    else prev_n <= lvl_n_i;
  end

  // new edge wins over a simultaneous ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend <= 1'b0;
    else if (fall && edge_sel_i && en_i) pend <= 1'b1;
    else if (ack_i || !edge_sel_i) pend <= 1'b0;
  end

  assign active_o = en_i & (edge_sel_i ? pend : ~lvl_n_i);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_ctrl_pkg::*;
(
  input  logic    mreq_i,
  input  logic    imask_i,
  input  logic    nmi_lvl_n_i,
  input  logic    xmask_i,
  output req_id_e id_o
);
  always_comb begin
    if (!nmi_lvl_n_i && !xmask_i) id_o = REQ_NMI;
    else if (mreq_i && !imask_i)  id_o = REQ_MASK;
    else                          id_o = REQ_NONE;
  end
endmodule

// File: rtl/irq_rst_vec.sv
module irq_rst_vec #(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] VEC_CLKMON = 16'hFFFC,
  parameter logic [AW-1:0] VEC_COP    = 16'hFFFA,
  parameter logic [AW-1:0] VEC_NORMAL = 16'hFFFE
) (
  input  logic          cop_pend_i,
  input  logic          clkmon_pend_i,
  output logic [AW-1:0] vec_o
);
  always_comb begin
    if (clkmon_pend_i)   vec_o = VEC_CLKMON;
    else if (cop_pend_i) vec_o = VEC_COP;
    else                 vec_o = VEC_NORMAL;
  end
endmodule

// File: rtl/irq_input_ctrl.sv
module irq_input_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_ni,
  input  logic          nmi_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_wdata_i,
  output logic [1:0]    cfg_o,
  input  logic          imask_i,
  input  logic          xmask_we_i,
  input  logic          xmask_wdata_i,
  output logic          xmask_o,
  input  logic          ack_i,
  output logic [1:0]    pin_lvl_o,
  output logic          req_o,
  output logic [1:0]    req_id_o,
  input  logic          cop_pend_i,
  input  logic          clkmon_pend_i,
  output logic [AW-1:0] rst_vec_o
);
  localparam int NPIN = 2;

  cfg_t         cfg_q;
  logic         xmask_q;
  logic [NPIN-1:0] lvl_n;
  logic         mreq;
  req_id_e      id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  // one-way clear; only reset sets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xmask_q <= 1'b1;
    else if (xmask_we_i && !xmask_wdata_i) xmask_q <= 1'b0;
  end

  irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nmi_ni, irq_ni}),
    .q_o   (lvl_n)
  );

  irq_edge_cap u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_n_i   (lvl_n[0]),
    .en_i      (cfg_q.en),
    .edge_sel_i(cfg_q.edge_sel),
    .ack_i     (ack_i),
    .active_o  (mreq)
  );

  irq_arb u_arb (
    .mreq_i     (mreq),
    .imask_i    (imask_i),
    .nmi_lvl_n_i(lvl_n[1]),
    .xmask_i    (xmask_q),
    .id_o       (id)
  );

  irq_rst_vec #(.AW(AW)) u_vec (
    .cop_pend_i   (cop_pend_i),
    .clkmon_pend_i(clkmon_pend_i),
    .vec_o        (rst_vec_o)
  );

  assign cfg_o     = cfg_q;
  assign xmask_o   = xmask_q;
  assign pin_lvl_o = lvl_n;
  assign req_id_o  = id;
  assign req_o     = (id != REQ_NONE);
endmodule

// File: rtl/irq_input_ctrl_chk.sv
module irq_input_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    cfg_o,
  input logic          imask_i,
  input logic          xmask_o,
  input logic [1:0]    pin_lvl_o,
  input logic          req_o,
  input logic [1:0]    req_id_o,
  input logic          cop_pend_i,
  input logic          clkmon_pend_i,
  input logic [AW-1:0] rst_vec_o
);
  a_r9_xmask_no_reset_by_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xmask_o |=> !xmask_o);

  a_r10_nmi_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_lvl_o[1] && !xmask_o) |-> (req_id_o == 2'b10));

  a_r9_nmi_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmask_o |-> (req_id_o != 2'b10));

  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_o[0] |-> (req_id_o != 2'b01));

  a_r8_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask_i |-> (req_id_o != 2'b01));

  a_r3_level_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o == 2'b01 && !pin_lvl_o[0] && !imask_i && !(xmask_o == 1'b0 && !pin_lvl_o[1]))
      |-> (req_id_o == 2'b01));

  a_r10_req_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o == (req_id_o != 2'b00));

  a_r11_clkmon_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkmon_pend_i |-> (rst_vec_o == 16'hFFFC));

  a_r11_cop_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_pend_i && !clkmon_pend_i) |-> (rst_vec_o == 16'hFFFA));
endmodule

bind irq_input_ctrl irq_input_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_o        (cfg_o),
  .imask_i      (imask_i),
  .xmask_o      (xmask_o),
  .pin_lvl_o    (pin_lvl_o),
  .req_o        (req_o),
  .req_id_o     (req_id_o),
  .cop_pend_i   (cop_pend_i),
  .clkmon_pend_i(clkmon_pend_i),
  .rst_vec_o    (rst_vec_o)
);

// File: tb/irq_input_ctrl_tb.sv
module irq_input_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_ni = 1'b1, nmi_ni = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_wdata_i = 2'b00;
  logic [1:0]  cfg_o;
  logic        imask_i = 1'b0;
  logic        xmask_we_i = 1'b0, xmask_wdata_i = 1'b0;
  logic        xmask_o;
  logic        ack_i = 1'b0;
  logic [1:0]  pin_lvl_o;
  logic        req_o;
  logic [1:0]  req_id_o;
  logic        cop_pend_i = 1'b0, clkmon_pend_i = 1'b0;
  logic [15:0] rst_vec_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk_i = ~clk_i;

  irq_input_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic cfg_wr(input logic [1:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic xm_wr(input logic v);
    xmask_we_i = 1'b1; xmask_wdata_i = v;
    tick();
    xmask_we_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick();
    // R2 reset state
    chk("R2 cfg", cfg_o, 2'b01);
    chk("R2 xmask", xmask_o, 1);
    chk("R2 req_id", req_id_o, 0);
    chk("R2 pins", pin_lvl_o, 2'b11);

    // R11 vector sweep
    for (int v = 0; v < 4; v++) begin
      clkmon_pend_i = v[1]; cop_pend_i = v[0];
      #1;
      chk("R11 vec", rst_vec_o, v[1] ? 16'hFFFC : (v[0] ? 16'hFFFA : 16'hFFFE));
    end
    clkmon_pend_i = 0; cop_pend_i = 0;

    // R1 sync latency, with enable off
    cfg_wr(2'b00);
    chk("R12 cfg write", cfg_o, 2'b00);
    irq_ni = 0; nmi_ni = 0;
    tick();
    chk("R1 one edge", pin_lvl_o, 2'b11);
    tick();
    chk("R1 two edges", pin_lvl_o, 2'b00);
    irq_ni = 1; nmi_ni = 1;
    tick(2);
    chk("R1 release", pin_lvl_o, 2'b11);

    // R3/R7/R8/R9/R10 level sweep, before and after xmask clear
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) begin
        xm_wr(1'b1);
        chk("R9 write one ignored", xmask_o, 1);
        xm_wr(1'b0);
        chk("R9 cleared", xmask_o, 0);
        xm_wr(1'b1);
        chk("R9 cannot reset", xmask_o, 0);
      end
      for (int c = 0; c < 16; c++) begin
        logic en, im, ip, np;
        logic [1:0] exp;
        en = c[0]; im = c[1]; ip = c[2]; np = c[3];
        cfg_wr({1'b0, en});
        imask_i = im; irq_ni = ip; nmi_ni = np;
        tick(2);
        exp = (!np && ph == 1) ? 2'b10 : ((en && !ip && !im) ? 2'b01 : 2'b00);
        chk("R3 R7 R8 R9 R10 sweep id", req_id_o, exp);
        chk("R10 req flag", req_o, exp != 0);
      end
    end
    nmi_ni = 1; irq_ni = 1; imask_i = 0;
    tick(2);

    // R3 latency and release
    cfg_wr(2'b01);
    irq_ni = 0;
    tick();
    chk("R3 one edge", req_id_o, 0);
    tick();
    chk("R3 two edges", req_id_o, 2'b01);
    irq_ni = 1;
    tick(2);
    chk("R3 release", req_id_o, 0);

    // R8 same-cycle unmask
    imask_i = 1; irq_ni = 0;
    tick(2);
    chk("R8 masked", req_id_o, 0);
    imask_i = 0;
    #1;
    chk("R8 unmask immediate", req_id_o, 2'b01);
    irq_ni = 1;
    tick(2);

    // R4 edge mode
    cfg_wr(2'b11);
    irq_ni = 0;
    tick(2);
    chk("R4 not yet", req_id_o, 0);
    tick();
    chk("R4 latched", req_id_o, 2'b01);
    irq_ni = 1;
    tick(3);
    chk("R4 sticky", req_id_o, 2'b01);
    // R5 ack collides with new edge
    irq_ni = 0;
    tick(2);
    ack_i = 1;
    tick();
    ack_i = 0;
    chk("R5 collision keeps pend", req_id_o, 2'b01);
    tick();
    chk("R5 still pending", req_id_o, 2'b01);
    ack_i = 1;
    tick();
    ack_i = 0;
    chk("R4 ack clears", req_id_o, 0);
    irq_ni = 1;
    tick(3);
    chk("R4 rise no request", req_id_o, 0);

    // R6 level select clears pending
    irq_ni = 0; tick(3); irq_ni = 1; tick(3);
    chk("R6 pend set", req_id_o, 2'b01);
    cfg_wr(2'b01);
    tick();
    chk("R6 level mode pin high", req_id_o, 0);
    cfg_wr(2'b11);
    chk("R6 pend cleared", req_id_o, 0);

    // R7 edge while disabled not latched
    cfg_wr(2'b10);
    irq_ni = 0; tick(3); irq_ni = 1; tick(2);
    cfg_wr(2'b11);
    chk("R7 no latch while off", req_id_o, 0);

    // R10 priority in edge mode
    irq_ni = 0; tick(3);
    nmi_ni = 0; tick(2);
    chk("R10 nmi wins", req_id_o, 2'b10);
    nmi_ni = 1; tick(2);
    chk("R10 back to maskable", req_id_o, 2'b01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule